// File: doc/BRIEF.md
# Dual Selectable-Ratio Clock Divider

This block derives two slower clocks, A and B, from one input clock. Each output has its own 2-bit ratio select. Output A runs at the input rate or at one half, one quarter or one eighth of it. Output B always divides, by 2, 4, 8 or 16. Both outputs are taken from taps of one shared free-running phase counter, so every rising edge of the slower output falls on a rising edge of the faster one. In pass-through mode, output A is the input clock itself, with its rising edges on B's.

Each output has an enable. The enable is sampled on the falling edge of the input clock and only acts while that output is low, so a pulse is never cut short or started part-way. A master reset clears the counter and stages fresh selects. Several copies that leave reset on the same clock edge therefore run in lockstep. A new select value waits in a staging register until the counter wraps, so a ratio change never produces a pulse of an intermediate length.

Top module: `dual_ratio_divider`

## Requirements
- R1: Output A divides the input clock by 1, 2, 4 or 8 for `rsel_a` values 0, 1, 2 and 3. For ratios of 2 and above the duty cycle is exactly 50%; at ratio 1 the output equals the input clock.
- R2: Output B divides the input clock by 2, 4, 8 or 16 for `rsel_b` values 0, 1, 2 and 3, with exactly 50% duty cycle.
- R3: Every rising edge of the output with the larger ratio coincides with a rising edge of the other output. At ratio 1, output A rises on each rising input-clock edge, together with B.
- R4: `mrst` is an active-high reset sampled on the input clock. Once it has been seen, both outputs stay low for as long as it is held. After release, the output waveform depends only on the selects and enables, not on earlier history.
- R5: An enable that drops while its output is high takes effect only after that high phase ends. Every high pulse therefore has the full length set by the ratio.
- R6: A disabled output stays low. When the enable returns, the output resumes with full-length pulses.
- R7: A select change while running takes effect only when the shared counter wraps to zero. That point is a rising edge of B at ratio 16. Before it, the old ratio continues; after it, the new ratio runs, with no pulse of any other length.
- R8: Selects presented while `mrst` is held apply from the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| mrst | input | 1 | Master reset, active high, synchronous |
| rsel_a | input | 2 | Ratio select for output A (0..3 gives 1, 2, 4, 8) |
| rsel_b | input | 2 | Ratio select for output B (0..3 gives 2, 4, 8, 16) |
| en_a | input | 1 | Enable for output A, sampled on the falling clock edge |
| en_b | input | 1 | Enable for output B, sampled on the falling clock edge |
| out_a | output | 1 | Divided clock A |
| out_b | output | 1 | Divided clock B |

## Verification
An enable can drop in the same cycle that its output is in the middle of a high phase. An enable can also return while the other output is rising. The bench provokes the first case by waiting until an output is seen high and then dropping its enable one edge later. It then requires every complete high pulse to keep its full ratio length, the disabled stretch to stay low, and the pulses to come back after re-enable. A select change can also land mid-count while the other output keeps running. The bench judges that case by where the first pulse of the new length begins: it must start on a rising edge of output B at ratio 16.

// File: rtl/dual_div_pkg.sv
package dual_div_pkg;

    // Width of one ratio select; the ratio range of both outputs follows from it.
    localparam int SEL_W  = 2;
    // Counter wide enough for the largest ratio of the offset output (2^(2^SEL_W)).
    localparam int CNT_W  = 1 << SEL_W;
    // Number of divided outputs.
    localparam int NUM_CH = 2;

    typedef logic [SEL_W-1:0] ratio_sel_t;
    typedef logic [CNT_W-1:0] phase_cnt_t;

    // Staged select pair, updated only at reset or counter wrap.
    typedef struct packed {
        ratio_sel_t sel_a;
        ratio_sel_t sel_b;
    } sel_pair_t;

    // Decoded tap: either pass the input clock through, or take one counter bit.
    typedef struct packed {
        logic             bypass;
        logic [SEL_W-1:0] bit_idx;
    } tap_t;

    // Ratio exponent = select + channel offset; exponent 0 means pass-through,
    // exponent e >= 1 uses counter bit e-1.
    function automatic tap_t decode_tap(ratio_sel_t sel, int unsigned off);
        logic [SEL_W:0] expo;
        tap_t           t;
        expo      = {1'b0, sel} + (SEL_W+1)'(off);
        t.bypass  = (expo == '0);
        t.bit_idx = SEL_W'(expo - 1'b1);
        return t;
    endfunction

endpackage

// File: rtl/phase_counter.sv
module phase_counter
    import dual_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sel_pair_t  sel_in,
    output phase_cnt_t cnt_q,
    output sel_pair_t  sel_q
);

    localparam phase_cnt_t LAST = '1;

    logic wrap_next;
    assign wrap_next = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sel_q <= sel_in;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (wrap_next) begin
                sel_q <= sel_in;
            end
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (cnt_q == phase_cnt_t'($past(cnt_q) + 1'b1)))
        else $error("counter skipped a step"); // R1

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $stable(sel_q))
        else $error("staged select moved away from wrap"); // R7

endmodule

// File: rtl/tap_pick.sv
module tap_pick
    import dual_div_pkg::*;
#(
    parameter int unsigned OFFSET = 0
) (
    input  phase_cnt_t cnt,
    input  ratio_sel_t sel,
    output logic       bypass,
    output logic       lvl
);

    tap_t tap;

    always_comb begin
        tap    = decode_tap(sel, OFFSET);
        bypass = tap.bypass;
        // Inverted tap: every tap rises when the counter returns to zero.
        lvl    = ~cnt[tap.bit_idx];
    end

endmodule

// File: rtl/out_gate.sv
module out_gate (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic bypass,
    input  logic lvl,
    output logic q
);

    logic gate_q;
    logic src;
    logic src_low;
    logic rst_seen;

    assign src     = bypass ? clk : lvl;
    // At a falling edge the pass-through source is always low.
    assign src_low = bypass | ~lvl;

    always_ff @(negedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
        end else if (src_low) begin
            gate_q <= en;
        end
    end

    always_ff @(negedge clk) begin
        rst_seen <= rst;
    end

    assign q = src & gate_q;

    AST_GATE_SAFE: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && (gate_q != $past(gate_q))) |-> ($past(bypass) || !$past(lvl)))
        else $error("gate moved during a high phase"); // R5

    always @(posedge clk) begin
        if (rst_seen && rst) begin
            AST_RST_QUIET: assert (q == 1'b0)
                else $error("output high while reset held"); // R4
        end
    end

endmodule

// File: rtl/dual_ratio_divider.sv
module dual_ratio_divider
    import dual_div_pkg::*;
(
    input  logic             clk_in,
    input  logic             mrst,
    input  logic [SEL_W-1:0] rsel_a,
    input  logic [SEL_W-1:0] rsel_b,
    input  logic             en_a,
    input  logic             en_b,
    output logic             out_a,
    output logic             out_b
);

    sel_pair_t   sel_in;
    sel_pair_t   sel_q;
    phase_cnt_t  cnt;
    ratio_sel_t  ch_sel [NUM_CH];
    logic [NUM_CH-1:0] ch_en;
    logic [NUM_CH-1:0] ch_out;

    always_comb begin
        sel_in.sel_a = rsel_a;
        sel_in.sel_b = rsel_b;
        ch_sel[0]    = sel_q.sel_a;
        ch_sel[1]    = sel_q.sel_b;
        ch_en        = {en_b, en_a};
    end

    phase_counter u_cnt (
        .clk    (clk_in),
        .rst    (mrst),
        .sel_in (sel_in),
        .cnt_q  (cnt),
        .sel_q  (sel_q)
    );

    // Channel n uses ratio exponent (select + n): A covers 1..8, B covers 2..16.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic bypass;
        logic lvl;

        tap_pick #(.OFFSET(ch)) u_tap (
            .cnt    (cnt),
            .sel    (ch_sel[ch]),
            .bypass (bypass),
            .lvl    (lvl)
        );

        out_gate u_gate (
            .clk    (clk_in),
            .rst    (mrst),
            .en     (ch_en[ch]),
            .bypass (bypass),
            .lvl    (lvl),
            .q      (ch_out[ch])
        );
    end

    assign out_a = ch_out[0];
    assign out_b = ch_out[1];

endmodule

// File: tb/dual_ratio_divider_tb.sv
`timescale 1ns/1ps
module dual_ratio_divider_tb;

    logic       clk_in = 1'b0;
    logic       mrst   = 1'b1;
    logic [1:0] rsel_a = '0;
    logic [1:0] rsel_b = '0;
    logic       en_a   = 1'b1;
    logic       en_b   = 1'b1;
    logic       out_a;
    logic       out_b;

    int n_chk  = 0;
    int n_fail = 0;

    logic [511:0] cap_a;
    logic [511:0] cap_b;

    always #5 clk_in = ~clk_in;

    dual_ratio_divider u_dut (
        .clk_in (clk_in),
        .mrst   (mrst),
        .rsel_a (rsel_a),
        .rsel_b (rsel_b),
        .en_a   (en_a),
        .en_b   (en_b),
        .out_a  (out_a),
        .out_b  (out_b)
    );

    // {sel_a, sel_b, expected A high/low length, expected B high/low length}
    // Lengths are in half-cycle samples: ratio 1 -> 1, ratio N>=2 -> N.
    localparam int VEC [16][4] = '{
        '{0,0,1,2},  '{0,1,1,4},  '{0,2,1,8},  '{0,3,1,16},
        '{1,0,2,2},  '{1,1,2,4},  '{1,2,2,8},  '{1,3,2,16},
        '{2,0,4,2},  '{2,1,4,4},  '{2,2,4,8},  '{2,3,4,16},
        '{3,0,8,2},  '{3,1,8,4},  '{3,2,8,8},  '{3,3,8,16}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk_in);
        #1;
    endtask

    // Two samples per input cycle: mid high phase, then mid low phase.
    task automatic capture(input int cyc);
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk_in);
            #2;
            cap_a[2*i] = out_a;
            cap_b[2*i] = out_b;
            #5;
            cap_a[2*i+1] = out_a;
            cap_b[2*i+1] = out_b;
        end
    endtask

    task automatic do_reset(input logic [1:0] sa, input logic [1:0] sb);
        @(posedge clk_in);
        #1;
        mrst   = 1'b1;
        rsel_a = sa;
        rsel_b = sb;
        step(4);
        mrst = 1'b0;
    endtask

    // Completed run lengths after the first rising transition.
    task automatic run_stats(input logic [511:0] v, input int n,
                             output int hmin, output int hmax,
                             output int lmin, output int lmax,
                             output int nhi, output int longest_lo);
        bit started = 0;
        int cur     = 1;
        hmin = 9999; hmax = 0; lmin = 9999; lmax = 0; nhi = 0; longest_lo = 0;
        for (int i = 1; i < n; i++) begin
            if (v[i] != v[i-1]) begin
                if (started) begin
                    if (v[i-1]) begin
                        nhi++;
                        if (cur < hmin) hmin = cur;
                        if (cur > hmax) hmax = cur;
                    end else begin
                        if (cur < lmin) lmin = cur;
                        if (cur > lmax) lmax = cur;
                        if (cur > longest_lo) longest_lo = cur;
                    end
                end
                if (v[i]) started = 1;
                cur = 1;
            end else begin
                cur++;
            end
        end
        if (started && !v[n-1] && cur > longest_lo) longest_lo = cur;
    endtask

    // Rising edges of 'slow' with no rising edge of 'fast' in the same sample.
    function automatic int align_err(input logic [511:0] slow, input logic [511:0] fast,
                                     input int n, output int rises);
        int e = 0;
        rises = 0;
        for (int i = 1; i < n; i++) begin
            if (slow[i] && !slow[i-1]) begin
                rises++;
                if (!(fast[i] && !fast[i-1])) e++;
            end
        end
        return e;
    endfunction

    initial begin
        #1_900_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete act=%0d exp=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int hmin, hmax, lmin, lmax, nhi, llo, rises, err;
        logic [511:0] ref_a, ref_b;

        // Reset state: outputs low while reset held (R4)
        mrst = 1'b1;
        step(3);
        capture(4);
        chk(cap_a[7:0] == 8'h00, "R4", "out_a during reset", int'(cap_a[7:0]), 0);
        chk(cap_b[7:0] == 8'h00, "R4", "out_b during reset", int'(cap_b[7:0]), 0);

        // All select combinations (R1, R2, R3, R8)
        for (int v = 0; v < 16; v++) begin
            int ea, eb;
            ea = VEC[v][2];
            eb = VEC[v][3];
            do_reset(2'(VEC[v][0]), 2'(VEC[v][1]));
            capture(128);
            run_stats(cap_a, 256, hmin, hmax, lmin, lmax, nhi, llo);
            chk(hmin == ea && hmax == ea, "R1 R8", "A high length", hmax, ea);
            chk(lmin == ea && lmax == ea, "R1 R8", "A low length", lmax, ea);
            run_stats(cap_b, 256, hmin, hmax, lmin, lmax, nhi, llo);
            chk(hmin == eb && hmax == eb, "R2 R8", "B high length", hmax, eb);
            chk(lmin == eb && lmax == eb, "R2 R8", "B low length", lmax, eb);
            if (eb >= ea) err = align_err(cap_b, cap_a, 256, rises);
            else          err = align_err(cap_a, cap_b, 256, rises);
            chk(err == 0 && rises > 2, "R3", "slow edges without fast edge", err, 0);
        end

        // Enable dropped mid-pulse, then restored (R5, R6)
        do_reset(2'd3, 2'd0);
        fork
            capture(128);
            begin
                while (out_a !== 1'b1) step(1);
                step(1);
                en_a = 1'b0;
                step(30);
                en_a = 1'b1;
            end
            begin
                while (out_b !== 1'b1) step(1);
                en_b = 1'b0;
                step(25);
                en_b = 1'b1;
            end
        join
        run_stats(cap_a, 256, hmin, hmax, lmin, lmax, nhi, llo);
        chk(hmin == 8 && hmax == 8, "R5", "A pulse length across disable", hmin, 8);
        chk(llo >= 44, "R6", "A low stretch while disabled", llo, 44);
        chk(cap_a[255:200] != '0, "R6", "A resumes after enable", 0, 1);
        run_stats(cap_b, 256, hmin, hmax, lmin, lmax, nhi, llo);
        chk(hmin == 2 && hmax == 2, "R5", "B pulse length across disable", hmin, 2);
        chk(llo >= 40, "R6", "B low stretch while disabled", llo, 40);

        // Pass-through enable toggling keeps whole clock pulses (R5)
        do_reset(2'd0, 2'd1);
        fork
            capture(64);
            begin
                for (int k = 0; k < 10; k++) begin
                    step(3);
                    en_a = ~en_a;
                end
                en_a = 1'b1;
            end
        join
        run_stats(cap_a, 128, hmin, hmax, lmin, lmax, nhi, llo);
        chk(hmin == 1 && hmax == 1, "R5", "pass-through pulse length", hmax, 1);

        // Select change waits for counter wrap (R7)
        do_reset(2'd1, 2'd3);
        fork
            capture(128);
            begin
                step(5);
                rsel_a = 2'd3;
            end
        join
        begin
            int cur, first8, bad, prev_len;
            cur = 0; first8 = -1; bad = 0; prev_len = 0;
            for (int i = 1; i < 256; i++) begin
                if (cap_a[i] && !cap_a[i-1]) cur = i;
                if (!cap_a[i] && cap_a[i-1] && cur > 0) begin
                    int len;
                    len = i - cur;
                    if (len != 2 && len != 8) bad++;
                    if (len == 8 && first8 < 0) first8 = cur;
                    if (len == 2 && first8 >= 0) bad++;
                    prev_len = len;
                end
            end
            chk(bad == 0, "R7", "pulses of wrong length around change", bad, 0);
            chk(first8 >= 0 && cap_b[first8] && !cap_b[first8-1], "R7",
                "new ratio starts on wrap edge", first8, 0);
            chk(first8 > 12, "R7", "old ratio kept until wrap", first8, 13);
        end

        // Lockstep after reset regardless of history (R4)
        do_reset(2'd2, 2'd1);
        capture(64);
        ref_a = cap_a;
        ref_b = cap_b;
        rsel_a = 2'd0;
        rsel_b = 2'd3;
        step(13);
        en_b = 1'b0;
        step(7);
        en_b = 1'b1;
        do_reset(2'd2, 2'd1);
        capture(64);
        chk(cap_a[127:0] == ref_a[127:0], "R4", "A waveform repeat after reset",
            int'(cap_a[31:0]), int'(ref_a[31:0]));
        chk(cap_b[127:0] == ref_b[127:0], "R4", "B waveform repeat after reset",
            int'(cap_b[31:0]), int'(ref_b[31:0]));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule